// File: doc/BRIEF.md
# Four-channel DMA register bank

This block holds the programming registers of a four-channel DMA engine. Software writes them one byte at a time. Each channel owns a twelve-byte window in a shared register space. The window holds a source address, a destination address, a transfer count and a control word. Every incoming byte is masked to the bits that exist on that channel. The stored control word is split into separate mode outputs.

When a write turns a channel's enable bit on from off, the bank copies the programmed source, destination and count into working latches. The transfer engine runs from those latches. If the newly written trigger field selects an immediate start, the bank also raises a one-cycle start request for that channel.

Reads are combinational from the address. Count bytes read as zero. Control bytes return the stored word. Source bytes, destination bytes and addresses outside the bank read as zero with an open-bus flag raised, so that a parent block can supply its own value in their place.

Top module: `dma_regbank`

## Requirements
- R1: Channel n (0..3) occupies byte addresses 0xB0+12n to 0xBB+12n, in this order:
  - source bytes 0..3, least significant first;
  - destination bytes 4..7;
  - count bytes 8..9;
  - control bytes 10..11.

  A write outside 0xB0..0xDF changes no register, no latch and no start request.
- R2: Source byte 3 keeps bits 2:0 on channel 0 and bits 3:0 on channels 1..3.
- R3: Destination byte 3 keeps bits 3:0 on channel 3 and bits 2:0 on channels 0..2.
- R4: Count byte 9 keeps bits 5:0 on channels 0..2, giving a 14-bit count. Channel 3 keeps all 8 bits, giving a 16-bit count.
- R5: A write to control byte 10 stores only bits 7:5.
  - `dst_mode` is control bits 6:5, encoded 0 increment, 1 decrement, 2 fixed, 3 increment-with-reload.
  - `src_mode` is {control bit 8, control bit 7}.
- R6: Control byte 11 holds the following fields, given as bits of the 16-bit control word:
  - bit 9: repeat;
  - bit 10: 32-bit width;
  - bit 11: external-request mode;
  - bits 13:12: trigger (0 immediate, 1 vblank, 2 hblank, 3 special);
  - bit 14: IRQ enable;
  - bit 15: enable.

  Bit 11 is forced to 0 on channels 0..2.
- R7: Writing control byte 11 with bit 7 set while the channel's enable is 0 copies the stored source, destination and count into `src_work`, `dst_work` and `cnt_work`. No other write changes those latches, including a write of enable=1 to an enabled channel.
- R8: The same 0-to-1 enable write with trigger field 0 raises that channel's `start_req` for exactly the following clock cycle. No other write raises it.
- R9: Reads are combinational from `addr`:
  - count bytes return 0 with `rd_openbus` low;
  - control bytes return the stored control bytes with `rd_openbus` low;
  - source bytes, destination bytes and addresses outside the bank return 0 with `rd_openbus` high.
- R10: After reset every register, latch, mode output and start request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte |
| rd_openbus | output | 1 | Read address has no readable content |
| chan_en | output | NCH | Enable bit per channel |
| start_req | output | NCH | One-cycle immediate start request per channel |
| src_work | output | NCH*32 | Working source latch per channel |
| dst_work | output | NCH*32 | Working destination latch per channel |
| cnt_work | output | NCH*16 | Working count latch per channel |
| dst_mode | output | NCH*2 | Destination address mode per channel |
| src_mode | output | NCH*2 | Source address mode per channel |
| repeat_en | output | NCH | Repeat bit per channel |
| wide | output | NCH | 32-bit width bit per channel |
| ext_req | output | NCH | External-request mode bit per channel |
| trig | output | NCH*2 | Trigger select per channel |
| irq_en | output | NCH | IRQ enable per channel |

## Verification
The assertions assume that `addr`, `wdata` and `wr_en` change only between clock edges and stay stable across each edge. The bench drives them one time unit after a rising edge and keeps `wr_en` high for a single cycle per write. The assertions also assume that the working latches move only on a write cycle. The stimulus therefore leaves gaps with `wr_en` low between writes, so that the hold check has idle cycles to observe.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;

  localparam int WIN_BYTES = 12;

  function automatic logic [7:0] src_top_mask(input int ch);
    return (ch == 0) ? 8'h07 : 8'h0F;
  endfunction

  function automatic logic [7:0] dst_top_mask(input int ch, input int nch);
    return (ch == nch - 1) ? 8'h0F : 8'h07;
  endfunction

  function automatic logic [7:0] cnt_hi_mask(input int ch, input int nch);
    return (ch == nch - 1) ? 8'hFF : 8'h3F;
  endfunction

  function automatic logic [7:0] ctrl_hi_mask(input int ch, input int nch);
    return (ch == nch - 1) ? 8'hFF : 8'hF7;
  endfunction

  localparam logic [7:0] CTRL_LO_MASK = 8'hE0;

endpackage

// File: rtl/dma_reg_decode.sv
module dma_reg_decode #(
  parameter int NCH = 4,
  parameter logic [7:0] BASE = 8'hB0,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [7:0]      addr,
  output logic            hit,
  output logic [CH_W-1:0] ch,
  output logic [3:0]      bidx
);
  import dma_reg_pkg::*;

  localparam int SPAN = NCH * WIN_BYTES;

  logic [8:0] off;

  always_comb begin
    off  = {1'b0, addr} - {1'b0, BASE};
    hit  = (addr >= BASE) && (int'(off) < SPAN);
    ch   = CH_W'(off / WIN_BYTES);
    bidx = 4'(off % WIN_BYTES);
  end
endmodule

// File: rtl/dma_reg_channel.sv
module dma_reg_channel #(
  parameter int CH  = 0,
  parameter int NCH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [3:0]  bidx,
  input  logic [7:0]  wdata,
  output logic [15:0] ctrl,
  output logic [31:0] src_work,
  output logic [31:0] dst_work,
  output logic [15:0] cnt_work,
  output logic        start_req
);
  import dma_reg_pkg::*;

  logic [31:0] src_q, dst_q;
  logic [15:0] cnt_q, ctrl_q;
  logic        en_rise;
  logic        imm_start;

  assign en_rise   = we && (bidx == 4'd11) && wdata[7] && !ctrl_q[15];
  assign imm_start = en_rise && (wdata[5:4] == 2'b00);
  assign ctrl      = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      ctrl_q    <= '0;
      src_work  <= '0;
      dst_work  <= '0;
      cnt_work  <= '0;
      start_req <= 1'b0;
    end else begin
      start_req <= imm_start;
      if (we) begin
        case (bidx)
          4'd0:  src_q[7:0]    <= wdata;
          4'd1:  src_q[15:8]   <= wdata;
          4'd2:  src_q[23:16]  <= wdata;
          4'd3:  src_q[31:24]  <= wdata & src_top_mask(CH);
          4'd4:  dst_q[7:0]    <= wdata;
          4'd5:  dst_q[15:8]   <= wdata;
          4'd6:  dst_q[23:16]  <= wdata;
          4'd7:  dst_q[31:24]  <= wdata & dst_top_mask(CH, NCH);
          4'd8:  cnt_q[7:0]    <= wdata;
          4'd9:  cnt_q[15:8]   <= wdata & cnt_hi_mask(CH, NCH);
          4'd10: ctrl_q[7:0]   <= wdata & CTRL_LO_MASK;
          4'd11: ctrl_q[15:8]  <= wdata & ctrl_hi_mask(CH, NCH);
          default: ;
        endcase
      end
      if (en_rise) begin
        src_work <= src_q;
        dst_work <= dst_q;
        cnt_work <= cnt_q;
      end
    end
  end
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH = 4,
  parameter logic [7:0] BASE = 8'hB0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [7:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            rd_openbus,
  output logic [NCH-1:0]  chan_en,
  output logic [NCH-1:0]  start_req,
  output logic [NCH*32-1:0] src_work,
  output logic [NCH*32-1:0] dst_work,
  output logic [NCH*16-1:0] cnt_work,
  output logic [NCH*2-1:0]  dst_mode,
  output logic [NCH*2-1:0]  src_mode,
  output logic [NCH-1:0]  repeat_en,
  output logic [NCH-1:0]  wide,
  output logic [NCH-1:0]  ext_req,
  output logic [NCH*2-1:0]  trig,
  output logic [NCH-1:0]  irq_en
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            hit;
  logic [CH_W-1:0] sel_ch;
  logic [3:0]      bidx;
  logic [15:0]     ctrl_a [NCH];

  dma_reg_decode #(.NCH(NCH), .BASE(BASE)) u_dec (
    .addr(addr), .hit(hit), .ch(sel_ch), .bidx(bidx)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic we_i;
    assign we_i = wr_en && hit && (sel_ch == CH_W'(i));

    dma_reg_channel #(.CH(i), .NCH(NCH)) u_ch (
      .clk(clk), .rst_n(rst_n), .we(we_i), .bidx(bidx), .wdata(wdata),
      .ctrl(ctrl_a[i]),
      .src_work(src_work[i*32 +: 32]),
      .dst_work(dst_work[i*32 +: 32]),
      .cnt_work(cnt_work[i*16 +: 16]),
      .start_req(start_req[i])
    );

    assign dst_mode[i*2 +: 2] = ctrl_a[i][6:5];
    assign src_mode[i*2 +: 2] = ctrl_a[i][8:7];
    assign repeat_en[i]       = ctrl_a[i][9];
    assign wide[i]            = ctrl_a[i][10];
    assign ext_req[i]         = ctrl_a[i][11];
    assign trig[i*2 +: 2]     = ctrl_a[i][13:12];
    assign irq_en[i]          = ctrl_a[i][14];
    assign chan_en[i]         = ctrl_a[i][15];
  end

  always_comb begin
    rdata      = 8'h00;
    rd_openbus = 1'b1;
    if (hit && bidx >= 4'd8) begin
      rd_openbus = 1'b0;
      if (bidx == 4'd10) rdata = ctrl_a[sel_ch][7:0];
      else if (bidx == 4'd11) rdata = ctrl_a[sel_ch][15:8];
    end
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 4,
  parameter logic [7:0] BASE = 8'hB0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [7:0]         addr,
  input logic [7:0]         rdata,
  input logic               rd_openbus,
  input logic [NCH-1:0]     start_req,
  input logic [NCH-1:0]     chan_en,
  input logic [NCH*2-1:0]   trig,
  input logic [NCH*32-1:0]  src_work
);
  localparam int TOP = int'(BASE) + NCH * 12;

  logic oob;
  assign oob = (int'(addr) < int'(BASE)) || (int'(addr) >= TOP);

  a_r9_openbus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_openbus |-> (rdata == 8'h00));

  a_r1_oob_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && oob) |=> (start_req == '0));

  a_r7_work_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_work));

  a_r8_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_req));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[i] |=> !start_req[i]);
    a_r8_start_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      start_req[i] |-> (chan_en[i] && trig[i*2 +: 2] == 2'b00));
  end
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .rd_openbus(rd_openbus), .start_req(start_req), .chan_en(chan_en),
  .trig(trig), .src_work(src_work)
);

// File: tb/dma_regbank_bench.sv
`timescale 1ns/1ps
module dma_regbank_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic rd_openbus;
  logic [NCH-1:0] chan_en, start_req, repeat_en, wide, ext_req, irq_en;
  logic [NCH*32-1:0] src_work, dst_work;
  logic [NCH*16-1:0] cnt_work;
  logic [NCH*2-1:0] dst_mode, src_mode, trig;

  always #10 clk = ~clk;

  dma_regbank u_dma_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_openbus(rd_openbus), .chan_en(chan_en),
    .start_req(start_req), .src_work(src_work), .dst_work(dst_work),
    .cnt_work(cnt_work), .dst_mode(dst_mode), .src_mode(src_mode),
    .repeat_en(repeat_en), .wide(wide), .ext_req(ext_req), .trig(trig),
    .irq_en(irq_en)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] d;
    logic       ob;
    string      tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] last_start;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.d || rd_openbus !== it.ob) begin
        errors++;
        $display("FAIL %s: read %h got data=%h ob=%b expected data=%h ob=%b",
                 it.tag, it.a, rdata, rd_openbus, it.d, it.ob);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    last_start = start_req;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] d, input logic ob, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    addr = a;
    it.a = a; it.d = d; it.ob = ob; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 src_work", src_work[31:0], 0);
    chk("R10 chan_en", 32'(chan_en), 0);
    chk("R10 start_req", 32'(start_req), 0);
    rd(8'hBB, 8'h00, 1'b0, "R10 ctrl hi");

    // channel 0 programming: R1 R2 R3 R4
    wr(8'hB0, 8'h11); wr(8'hB1, 8'h22); wr(8'hB2, 8'h33); wr(8'hB3, 8'hFF);
    wr(8'hB4, 8'h44); wr(8'hB5, 8'h55); wr(8'hB6, 8'h66); wr(8'hB7, 8'hFF);
    wr(8'hB8, 8'h34); wr(8'hB9, 8'hFF);
    wr(8'hBA, 8'hFF);
    rd(8'hBA, 8'hE0, 1'b0, "R5 ctrl lo mask");
    chk("R5 dst_mode ch0", 32'(dst_mode[1:0]), 3);
    chk("R5 src_mode ch0 low bit", 32'(src_mode[1:0]), 1);
    wr(8'hBB, 8'h8D);
    chk("R8 immediate start ch0", 32'(last_start), 32'h1);
    chk("R8 start drops", 32'(start_req), 0);
    chk("R2 src top ch0", src_work[31:0], 32'h07332211);
    chk("R3 dst top ch0", dst_work[31:0], 32'h07665544);
    chk("R4 count ch0", 32'(cnt_work[15:0]), 32'h3F34);
    rd(8'hBB, 8'h85, 1'b0, "R6 ext forced 0 ch0");
    chk("R5 src_mode ch0", 32'(src_mode[1:0]), 3);
    chk("R6 wide ch0", 32'(wide[0]), 1);
    chk("R6 ext ch0", 32'(ext_req[0]), 0);

    // R7 re-enable while enabled does not relatch or restart
    wr(8'hB0, 8'hAA);
    wr(8'hBB, 8'h85);
    chk("R7 no relatch", src_work[31:0], 32'h07332211);
    chk("R8 no restart", 32'(last_start), 0);
    wr(8'hBB, 8'h05);
    chk("R6 disable", 32'(chan_en[0]), 0);
    chk("R7 hold on disable", src_work[31:0], 32'h07332211);
    wr(8'hBB, 8'h85);
    chk("R7 relatch", src_work[31:0], 32'h073322AA);
    chk("R8 restart", 32'(last_start), 32'h1);

    // channel 1: R2 R3 R6
    wr(8'hBF, 8'hFF); wr(8'hC3, 8'hFF);
    wr(8'hC7, 8'h88);
    chk("R8 start ch1", 32'(last_start), 32'h2);
    chk("R2 src top ch1", src_work[63:32], 32'h0F000000);
    chk("R3 dst top ch1", dst_work[63:32], 32'h07000000);
    chk("R6 ext ch1", 32'(ext_req[1]), 0);

    // channel 2: R4 R5 R6 hblank trigger
    wr(8'hD1, 8'hFF); wr(8'hD0, 8'h01);
    wr(8'hD2, 8'h80);
    wr(8'hD3, 8'hA0);
    chk("R8 no start hblank", 32'(last_start), 0);
    chk("R4 count ch2", 32'(cnt_work[47:32]), 32'h3F01);
    chk("R6 trig ch2", 32'(trig[5:4]), 2);
    chk("R5 src_mode ch2", 32'(src_mode[5:4]), 1);
    chk("R5 dst_mode ch2", 32'(dst_mode[5:4]), 0);

    // channel 3: R2 R3 R4 R6
    wr(8'hD4, 8'h01); wr(8'hD5, 8'h02); wr(8'hD6, 8'h03); wr(8'hD7, 8'hFF);
    wr(8'hDB, 8'hFF);
    wr(8'hDC, 8'h78); wr(8'hDD, 8'hFF);
    wr(8'hDF, 8'hD8);
    chk("R8 no start vblank", 32'(last_start), 0);
    chk("R2 src top ch3", src_work[127:96], 32'h0F030201);
    chk("R3 dst top ch3", dst_work[127:96], 32'h0F000000);
    chk("R4 count ch3", 32'(cnt_work[63:48]), 32'hFF78);
    chk("R6 ext ch3", 32'(ext_req[3]), 1);
    chk("R6 irq ch3", 32'(irq_en[3]), 1);
    chk("R6 trig ch3", 32'(trig[7:6]), 1);
    rd(8'hDF, 8'hD8, 1'b0, "R9 ctrl read ch3");
    rd(8'hDC, 8'h00, 1'b0, "R9 count reads 0");
    rd(8'hDD, 8'h00, 1'b0, "R9 count hi reads 0");
    rd(8'hD4, 8'h00, 1'b1, "R9 source open bus");
    rd(8'hB5, 8'h00, 1'b1, "R9 dest open bus");

    // R1 out-of-range writes
    wr(8'hE0, 8'hFF);
    chk("R1 oob no start hi", 32'(last_start), 0);
    wr(8'hAF, 8'hFF);
    chk("R1 oob no start lo", 32'(last_start), 0);
    rd(8'hBB, 8'h85, 1'b0, "R1 ch0 ctrl intact");
    rd(8'hDE, 8'h00, 1'b0, "R1 ch3 ctrl lo intact");
    rd(8'hE0, 8'h00, 1'b1, "R9 oob open bus");
    chk("R1 ch0 latch intact", src_work[31:0], 32'h073322AA);

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule